// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block lets a clocked design use an external asynchronous static RAM of 32K words of 16 bits. A client offers one request at a time on a valid/ready handshake. A request carries a word address, write data, a read/write flag and two active-high byte-lane selects: select 0 covers bits 7:0 and select 1 covers bits 15:8. The controller turns each request into a sequence of active-low strobes to the memory: chip select, write strobe, output enable and the two byte-lane strobes. It also drives the address and a split data bus, which has an output word, a drive enable and an input word. The pad that joins the split bus to the shared pins sits outside the block.

The phase lengths come from nanosecond minimums given as parameters. Each one is converted to whole clock cycles, rounded up, with a floor of one cycle. With the default 10 ns clock the write strobe is low for 1 cycle, output enable is low for 2 cycles and the bus turnaround after a read is 1 cycle. A write is set up for one cycle, then pulsed, then held for one cycle. A read enables the memory with output enable still high, then lowers output enable and captures the data in the last low cycle. It returns that data with a one-cycle response pulse and then waits out the turnaround. The memory is deselected whenever no request is in service. A request with neither lane selected finishes at once and makes no memory access.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and straight after reset, chip select, write strobe, output enable and both lane strobes are high, the data drive enable is low, req_ready is high and rsp_valid is low.
- R2: A write holds the write strobe low for exactly WP_CYC cycles (1 by default), with chip select low. Lane select 0 lowers the lower-lane strobe (data bits 7:0) and lane select 1 lowers the upper-lane strobe (bits 15:8). A lane that is not selected keeps its stored byte.
- R3: During a write the data bus is driven from one cycle before the write strobe falls until one cycle after it rises. The address stays constant for as long as chip select is low.
- R4: Output enable stays high for the whole of a write, and the write strobe stays high for the whole of a read.
- R5: A read with a lane selected holds output enable low for RD_CYC cycles (2 by default). rsp_valid pulses for one cycle on the edge that ends the last of those cycles, which is the fourth clock edge after acceptance. Lanes that were not selected read as zero.
- R6: The data drive enable is low in the cycle before output enable falls and while it is low. After a read, output enable stays high for at least TA_CYC plus one cycles before the bus is driven again.
- R7: Chip select is high whenever req_ready is high, and chip select is high for at least one cycle between two accesses.
- R8: A request with both lane selects clear makes no memory access. As a read it answers with rsp_valid on the next edge and data zero. As a write it gives no response.
- R9: While an access is in progress req_ready is low. A request held valid in that time is accepted only once, after the current access ends, and a write completes with req_ready high again on the fourth edge after acceptance.
- R10: The controller and the memory never drive the data bus in the same cycle, including a write that directly follows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high lane selects, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Lower-lane strobe, active low |
| mem_ub_n | output | 1 | Upper-lane strobe, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory pins |

## Verification
The risky coincidence is the read-to-write turnaround. Output enable rising at the end of a read and the controller starting to drive write data both fall inside a three-cycle window, and a held request is accepted on the same edge that the previous access returns to idle. The bench provokes this by keeping req_valid high while it swaps a write for a read, and a read for a write. A behavioural memory model counts every cycle in which both sides drive the bus, measures how many output-enable-high cycles come before the drive starts again, and checks that the data read back is the word just written.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W        = 15,
  parameter int LANE_W        = 8,
  parameter int CLK_NS        = 10,
  parameter int WE_PULSE_NS   = 8,
  parameter int DATA_SETUP_NS = 6,
  parameter int ACCESS_NS     = 12,
  parameter int OE_ACCESS_NS  = 6,
  parameter int OUT_OFF_NS    = 7,
  localparam int DATA_W       = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int WP_NS  = (WE_PULSE_NS > DATA_SETUP_NS) ? WE_PULSE_NS : DATA_SETUP_NS;
  localparam int RD_NS  = (ACCESS_NS > OE_ACCESS_NS) ? ACCESS_NS : OE_ACCESS_NS;
  localparam int WP_RAW = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_RAW = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA_RAW = (OUT_OFF_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_CYC = (WP_RAW < 1) ? 1 : WP_RAW;
  localparam int RD_CYC = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int TA_CYC = (TA_RAW < 1) ? 1 : TA_RAW;
  localparam int CMAX_A = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
  localparam int CMAX   = (CMAX_A > TA_CYC) ? CMAX_A : TA_CYC;
  localparam int CNT_W  = $clog2(CMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RSET, S_RDAT, S_RTRN
  } state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [1:0]          be_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                rsp_q;
  logic                active;
  logic [DATA_W-1:0]   lane_mask;

  assign lane_mask = {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          if (req_be == 2'b00) begin
            if (!req_write) begin
              rsp_q   <= 1'b1;
              rdata_q <= '0;
            end
          end else begin
            state <= req_write ? S_WSET : S_RSET;
          end
        end
        S_WSET: begin
          state <= S_WPUL;
          cnt   <= CNT_W'(WP_CYC - 1);
        end
        S_WPUL: if (cnt == '0) state <= S_WHLD;
                else cnt <= cnt - 1'b1;
        S_WHLD: state <= S_IDLE;
        S_RSET: begin
          state <= S_RDAT;
          cnt   <= CNT_W'(RD_CYC - 1);
        end
        S_RDAT: if (cnt == '0) begin
          rdata_q <= mem_dq_i & lane_mask;
          rsp_q   <= 1'b1;
          state   <= S_RTRN;
          cnt     <= CNT_W'(TA_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_RTRN: if (cnt == '0) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign active    = (state != S_IDLE) && (state != S_RTRN);
  assign req_ready = (state == S_IDLE);
  assign mem_ce_n  = !active;
  assign mem_lb_n  = !(active && be_q[0]);
  assign mem_ub_n  = !(active && be_q[1]);
  assign mem_we_n  = (state != S_WPUL);
  assign mem_oe_n  = (state != S_RDAT);
  assign mem_dq_oe = (state == S_WSET) || (state == S_WPUL) || (state == S_WHLD);
  assign mem_dq_o  = wdata_q;
  assign mem_addr  = addr_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  localparam int SAT = TA_CYC + 2;
  localparam int SW  = $clog2(SAT + 1);
  logic [CNT_W:0] we_run;
  logic [SW-1:0]  oe_hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run    <= '0;
      oe_hi_run <= SW'(SAT);
    end else begin
      we_run <= !mem_we_n ? we_run + 1'b1 : '0;
      if (!mem_oe_n) oe_hi_run <= '0;
      else if (oe_hi_run < SW'(SAT)) oe_hi_run <= oe_hi_run + 1'b1;
    end
  end

  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lb_n && mem_ub_n));
  a_r2_we_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == (CNT_W+1)'(WP_CYC)));
  a_r3_data_before_we: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && $past(mem_dq_oe)));
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  a_r4_oe_we_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  a_r6_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && $past(!mem_dq_oe)));
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_run >= SW'(TA_CYC + 1)));
  a_r7_ready_standby: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);
  a_r5_rsp_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_oe_n);

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  sram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mem [256];
  logic [1:0]  oe_low;
  logic        model_drive, w_act, w_prev, dq_oe_prev, ce_prev;
  logic [15:0] pend_d, rd_word;
  logic        pend_lb, pend_ub;
  logic [7:0]  pend_a;
  int          wcnt = 0, contention = 0, setup_viol = 0, pulse_viol = 0;
  int          ce_windows = 0, oe_hi_cnt = 0, last_gap = 0;

  assign model_drive = !mem_ce_n && !mem_oe_n && mem_we_n && (!mem_lb_n || !mem_ub_n);
  assign w_act = !mem_ce_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);
  assign rd_word = (oe_low >= 2'd2) ? mem[mem_addr[7:0]] : 16'hDEAD;
  assign mem_dq_i[7:0]  = (model_drive && !mem_lb_n) ? rd_word[7:0]  : 8'hzz;
  assign mem_dq_i[15:8] = (model_drive && !mem_ub_n) ? rd_word[15:8] : 8'hzz;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    oe_low = 0; w_prev = 0; dq_oe_prev = 0; ce_prev = 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (w_act) begin
        pend_d <= mem_dq_o; pend_lb <= !mem_lb_n; pend_ub <= !mem_ub_n;
        pend_a <= mem_addr[7:0]; wcnt <= wcnt + 1;
        if (!dq_oe_prev || !mem_dq_oe) setup_viol <= setup_viol + 1;
      end else if (w_prev) begin
        if (pend_lb) mem[pend_a][7:0]  <= pend_d[7:0];
        if (pend_ub) mem[pend_a][15:8] <= pend_d[15:8];
        if (wcnt < 1) pulse_viol <= pulse_viol + 1;
        wcnt <= 0;
      end
      w_prev <= w_act;
      if (mem_dq_oe && model_drive) contention <= contention + 1;
      if (mem_dq_oe && !dq_oe_prev) last_gap <= oe_hi_cnt + 1;
      dq_oe_prev <= mem_dq_oe;
      oe_low <= (!mem_oe_n && !mem_ce_n) ? ((oe_low == 2'd3) ? oe_low : oe_low + 1'b1) : 2'd0;
      oe_hi_cnt <= mem_oe_n ? oe_hi_cnt + 1 : 0;
      if (ce_prev && !mem_ce_n) ce_windows <= ce_windows + 1;
      ce_prev <= mem_ce_n;
    end
  end

  task automatic issue(input bit w, input logic [14:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [14:0] a, input logic [15:0] d, input logic [1:0] be);
    int n = 1, we_low = 0; bit oe_seen = 0, drive_ok = 1, lane_ok = 1;
    issue(1, a, d, be);
    while (!req_ready && n < 20) begin
      if (!mem_we_n) begin
        we_low++;
        if (mem_ce_n || mem_lb_n != !be[0] || mem_ub_n != !be[1]) lane_ok = 0;
      end
      if (!mem_oe_n) oe_seen = 1;
      if (!mem_dq_oe) drive_ok = 0;
      @(negedge clk); n++;
    end
    check(we_low == 1, "R2 write strobe cycles", we_low, 1);
    check(lane_ok, "R2 lane strobes during write", {mem_ub_n, mem_lb_n}, ~be);
    check(!oe_seen, "R4 oe high in write", oe_seen, 0);
    check(drive_ok, "R3 data driven through write", drive_ok, 1);
    check(n == 4, "R9 write done cycle", n, 4);
  endtask

  task automatic do_read(input logic [14:0] a, input logic [1:0] be, input logic [15:0] exp);
    int n = 1, oe_cnt = 0; bit we_seen = 0;
    issue(0, a, 16'h0, be);
    while (!rsp_valid && n < 20) begin
      if (!mem_oe_n) oe_cnt++;
      if (!mem_we_n) we_seen = 1;
      @(negedge clk); n++;
    end
    check(n == 4, "R5 response latency", n, 4);
    check(oe_cnt == 2, "R5 oe low cycles", oe_cnt, 2);
    check(!we_seen, "R4 we high in read", we_seen, 0);
    check(rsp_rdata == exp, "R5 read data", rsp_rdata, exp);
    @(negedge clk);
    check(!rsp_valid, "R5 single pulse", rsp_valid, 0);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 strobes in reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
    check(!mem_dq_oe && req_ready && !rsp_valid, "R1 idle flags",
          {mem_dq_oe, req_ready, rsp_valid}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    check(mem_ce_n && req_ready, "R7 standby after reset", {mem_ce_n, req_ready}, 2'b11);
  endtask

  task automatic t_lanes;
    do_write(15'h1234, 16'hA5C3, 2'b11);
    do_read(15'h1234, 2'b11, 16'hA5C3);
    do_write(15'h1234, 16'h7E00, 2'b10);
    do_read(15'h1234, 2'b11, 16'h7EC3);
    do_read(15'h1234, 2'b01, 16'h00C3);
    do_read(15'h1234, 2'b10, 16'h7E00);
    do_write(15'h7FFF, 16'h1B2C, 2'b01);
    do_read(15'h7FFF, 2'b11, 16'h002C);
    do_write(15'h0000, 16'hFFFF, 2'b11);
    do_read(15'h0000, 2'b11, 16'hFFFF);
  endtask

  task automatic t_empty;
    int w0 = ce_windows; bit ce_low = 0;
    issue(0, 15'h0055, 16'h0, 2'b00);
    check(rsp_valid && rsp_rdata == 16'h0, "R8 empty read answer", {rsp_valid, rsp_rdata}, 17'h10000);
    issue(1, 15'h0055, 16'h9999, 2'b00);
    for (int i = 0; i < 4; i++) begin
      if (!mem_ce_n) ce_low = 1;
      if (rsp_valid) ce_low = 1;
      @(negedge clk);
    end
    check(!ce_low && ce_windows == w0, "R8 no access on empty", ce_windows, w0);
    do_read(15'h0055, 2'b11, 16'h0000);
  endtask

  task automatic t_back_to_back;
    int w0 = ce_windows; int n = 0; bit gap_ok = 1; logic [15:0] got = 16'hxxxx;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 15'h2A55; req_wdata = 16'h3C96; req_be = 2'b11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 0;
    check(!req_ready, "R9 ready low when busy", req_ready, 0);
    while (!req_ready) begin
      if (!mem_ce_n && mem_ce_n == req_ready) gap_ok = gap_ok;
      @(negedge clk);
    end
    check(mem_ce_n, "R7 deselect between accesses", mem_ce_n, 1);
    @(negedge clk);
    req_write = 1; req_addr = 15'h2A56; req_wdata = 16'h0F0F;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    got = rsp_rdata;
    check(got == 16'h3C96, "R9 held read data", got, 16'h3C96);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    check(ce_windows == w0 + 3, "R9 one accept per request", ce_windows, w0 + 3);
    check(last_gap == 3, "R6 turnaround before drive", last_gap, 3);
    do_read(15'h2A56, 2'b11, 16'h0F0F);
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_lanes();
    t_empty();
    t_back_to_back();
    repeat (3) @(negedge clk);
    check(contention == 0, "R10 bus contention", contention, 0);
    check(setup_viol == 0, "R3 data setup", setup_viol, 0);
    check(pulse_viol == 0, "R2 pulse minimum", pulse_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule